// File: doc/BRIEF.md
# Atomic Ordering Fence Expander

This block sits in the decode stage of a pipeline. It accepts one decoded instruction at a time over a valid/ready handshake and turns it into a short stream of micro-operations on a second valid/ready handshake. Atomic memory instructions (read-modify-write operations, load-reserved and store-conditional) carry two ordering bits: acquire and release. The block turns those bits into explicit fence micro-ops placed around the memory micro-op, so that later stages only have to execute plain fences and never have to interpret ordering annotations.

A release request puts a fence ahead of the memory micro-op. An acquire request puts a fence behind it. Both together give a three-entry sequence. Every other instruction passes through as a single micro-op. The last micro-op of each expansion is flagged. A new instruction is accepted only when the final micro-op of the current one is being taken, and then it is accepted in that same cycle, so back-to-back single micro-ops run at one per cycle.

Top module: `ordexp_fence_expander`

## Requirements
- R1: After a clock edge with `rst_n` low, `uop_valid` is 0 and `in_ready` is 1.
- R2: An instruction with `in_atomic`=0 is emitted as exactly one micro-op with `uop_kind`=2'b00 (plain), its payload unchanged and `uop_last`=1. Its acquire and release bits are ignored.
- R3: An atomic instruction with neither ordering bit set is emitted as one micro-op with `uop_kind`=2'b01 (atomic memory op) and `uop_last`=1.
- R4: An atomic instruction with only acquire set is emitted as two micro-ops: kind 2'b01 with last=0, then kind 2'b11 (trailing fence) with last=1.
- R5: An atomic instruction with only release set is emitted as two micro-ops: kind 2'b10 (leading fence) with last=0, then kind 2'b01 with last=1.
- R6: An atomic instruction with both bits set is emitted as kind 2'b10, then 2'b01, then 2'b11, with last=1 only on the third.
- R7: Fence micro-ops (kind bit 1 set) carry an all-zero payload. The atomic micro-op carries the instruction payload unchanged.
- R8: `in_ready` is 1 when no micro-op is pending, or when the pending micro-op has `uop_last`=1 and `uop_ready` is 1. Otherwise `in_ready` is 0.
- R9: While `uop_valid` is 1 and `uop_ready` is 0, the offered micro-op holds steady. Every micro-op of every accepted instruction is delivered exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_atomic | input | 1 | Instruction is an atomic memory instruction |
| in_acq | input | 1 | Acquire ordering requested |
| in_rel | input | 1 | Release ordering requested |
| in_payload | input | PAYLOAD_W | Instruction word passed downstream |
| uop_valid | output | 1 | Micro-op offered |
| uop_ready | input | 1 | Downstream takes the micro-op |
| uop_kind | output | 2 | 00 plain, 01 atomic op, 10 leading fence, 11 trailing fence |
| uop_payload | output | PAYLOAD_W | Micro-op payload (zero for fences) |
| uop_last | output | 1 | Final micro-op of the current instruction |

## Verification
Directed single instructions cover the four acquire/release combinations on atomics, and a plain instruction with both bits set. Together they tell apart fence placement, fence count, and whether the bits are wrongly applied to non-atomics. A release-and-acquire atomic held under a long stall shows whether a micro-op is dropped or repeated while the sink is blocked. Long random streams with random sink readiness then mix single-entry and multi-entry expansions back to back, which exposes any error in the same-cycle handover of `in_ready` on the final micro-op.

// File: rtl/ordexp_pkg.sv
// Shared types for the ordering fence expander.
// Assumes: uop kind codes are decoded by downstream stages and must not change.
package ordexp_pkg;

    typedef enum logic [1:0] {
        UK_PLAIN      = 2'b00,
        UK_ATOMIC     = 2'b01,
        UK_FENCE_PRE  = 2'b10,
        UK_FENCE_POST = 2'b11
    } uop_kind_e;

    typedef enum logic [1:0] {
        PH_PRE  = 2'd0,
        PH_OP   = 2'd1,
        PH_POST = 2'd2
    } phase_e;

endpackage

// File: rtl/ordexp_plan.sv
// Decides the shape of an expansion from the incoming ordering bits.
// Assumes: ordering bits are meaningful only when the instruction is atomic.
module ordexp_plan
    import ordexp_pkg::*;
(
    input  logic   is_atomic,
    input  logic   acq,
    input  logic   rel,
    output phase_e start_phase,
    output logic   want_post
);

    // Release on an atomic starts with a fence; acquire adds one at the end.
    always_comb begin
        start_phase = (is_atomic && rel) ? PH_PRE : PH_OP;
        want_post   = is_atomic && acq;
    end

endmodule

// File: rtl/ordexp_seq.sv
// Holds one accepted instruction and steps through its expansion phases.
// Assumes: in_fire may coincide with uop_fire only on the final micro-op.
module ordexp_seq
    import ordexp_pkg::*;
#(
    parameter int PAYLOAD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_fire,
    input  logic                 in_atomic,
    input  logic [PAYLOAD_W-1:0] in_payload,
    input  phase_e               start_phase,
    input  logic                 want_post,
    input  logic                 uop_fire,
    input  logic                 cur_last,
    output logic                 busy,
    output phase_e               phase,
    output logic                 held_atomic,
    output logic                 held_post,
    output logic [PAYLOAD_W-1:0] held_payload
);

    logic                 busy_q;
    phase_e               phase_q;
    logic                 atomic_q;
    logic                 post_q;
    logic [PAYLOAD_W-1:0] payload_q;
    phase_e               phase_next;

    // Next phase after the current micro-op is taken.
    always_comb begin
        unique case (phase_q)
            PH_PRE:  phase_next = PH_OP;
            PH_OP:   phase_next = PH_POST;
            default: phase_next = PH_POST;
        endcase
    end

    // Capture a new instruction, or advance / retire the held one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            phase_q   <= PH_OP;
            atomic_q  <= 1'b0;
            post_q    <= 1'b0;
            payload_q <= '0;
        end else if (in_fire) begin
            busy_q    <= 1'b1;
            phase_q   <= start_phase;
            atomic_q  <= in_atomic;
            post_q    <= want_post;
            payload_q <= in_payload;
        end else if (uop_fire) begin
            if (cur_last) begin
                busy_q <= 1'b0;
            end else begin
                phase_q <= phase_next;
            end
        end
    end

    assign busy         = busy_q;
    assign phase        = phase_q;
    assign held_atomic  = atomic_q;
    assign held_post    = post_q;
    assign held_payload = payload_q;

endmodule

// File: rtl/ordexp_emit.sv
// Forms the offered micro-op from the held instruction and its phase.
// Assumes: phase PH_POST is reached only when a trailing fence was planned.
module ordexp_emit
    import ordexp_pkg::*;
#(
    parameter int PAYLOAD_W = 32
) (
    input  phase_e               phase,
    input  logic                 held_atomic,
    input  logic                 held_post,
    input  logic [PAYLOAD_W-1:0] held_payload,
    output uop_kind_e            kind,
    output logic                 last,
    output logic [PAYLOAD_W-1:0] payload
);

    // Map the phase to kind, last flag and payload.
    always_comb begin
        unique case (phase)
            PH_PRE: begin
                kind    = UK_FENCE_PRE;
                last    = 1'b0;
                payload = '0;
            end
            PH_OP: begin
                kind    = held_atomic ? UK_ATOMIC : UK_PLAIN;
                last    = !held_post;
                payload = held_payload;
            end
            PH_POST: begin
                kind    = UK_FENCE_POST;
                last    = 1'b1;
                payload = '0;
            end
            default: begin
                kind    = UK_PLAIN;
                last    = 1'b1;
                payload = '0;
            end
        endcase
    end

endmodule

// File: rtl/ordexp_fence_expander.sv
// Top: expands atomic instructions into fence / op / fence micro-op streams.
// Assumes: decode has already flagged atomics and extracted the ordering bits.
module ordexp_fence_expander
    import ordexp_pkg::*;
#(
    parameter int PAYLOAD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_atomic,
    input  logic                 in_acq,
    input  logic                 in_rel,
    input  logic [PAYLOAD_W-1:0] in_payload,
    output logic                 uop_valid,
    input  logic                 uop_ready,
    output logic [1:0]           uop_kind,
    output logic [PAYLOAD_W-1:0] uop_payload,
    output logic                 uop_last
);

    phase_e               start_phase;
    logic                 want_post;
    logic                 busy;
    phase_e               phase;
    logic                 held_atomic;
    logic                 held_post;
    logic [PAYLOAD_W-1:0] held_payload;
    uop_kind_e            kind_w;
    logic                 last_w;
    logic                 in_fire;
    logic                 uop_fire;

    // Handshake: accept when idle, or when the final micro-op leaves now.
    assign uop_valid = busy;
    assign uop_fire  = busy && uop_ready;
    assign in_ready  = !busy || (last_w && uop_ready);
    assign in_fire   = in_valid && in_ready;
    assign uop_kind  = kind_w;
    assign uop_last  = last_w;

    ordexp_plan u_plan (
        .is_atomic   (in_atomic),
        .acq         (in_acq),
        .rel         (in_rel),
        .start_phase (start_phase),
        .want_post   (want_post)
    );

    ordexp_seq #(.PAYLOAD_W(PAYLOAD_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_fire      (in_fire),
        .in_atomic    (in_atomic),
        .in_payload   (in_payload),
        .start_phase  (start_phase),
        .want_post    (want_post),
        .uop_fire     (uop_fire),
        .cur_last     (last_w),
        .busy         (busy),
        .phase        (phase),
        .held_atomic  (held_atomic),
        .held_post    (held_post),
        .held_payload (held_payload)
    );

    ordexp_emit #(.PAYLOAD_W(PAYLOAD_W)) u_emit (
        .phase        (phase),
        .held_atomic  (held_atomic),
        .held_post    (held_post),
        .held_payload (held_payload),
        .kind         (kind_w),
        .last         (last_w),
        .payload      (uop_payload)
    );

endmodule

// File: rtl/ordexp_fence_expander_chk.sv
// Protocol and ordering checks for the fence expander, bound to the top.
// Assumes: observes top-level ports only.
module ordexp_fence_expander_chk #(
    parameter int PAYLOAD_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_ready,
    input logic                 uop_valid,
    input logic                 uop_ready,
    input logic [1:0]           uop_kind,
    input logic [PAYLOAD_W-1:0] uop_payload,
    input logic                 uop_last
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!uop_valid && in_ready));

    // R2
    plain_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_kind == 2'b00) |-> uop_last);

    // R4
    acq_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && uop_kind == 2'b01 && !uop_last)
        |=> (uop_valid && uop_kind == 2'b11 && uop_last));

    // R5
    rel_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && uop_kind == 2'b10)
        |=> (uop_valid && uop_kind == 2'b01));

    // R7
    fence_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_kind[1]) |-> (uop_payload == '0));

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_last) |-> !in_ready);

    // R8
    idle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uop_valid |-> in_ready);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready)
        |=> (uop_valid && $stable(uop_kind) && $stable(uop_payload) && $stable(uop_last)));

endmodule

bind ordexp_fence_expander ordexp_fence_expander_chk #(.PAYLOAD_W(PAYLOAD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .uop_valid   (uop_valid),
    .uop_ready   (uop_ready),
    .uop_kind    (uop_kind),
    .uop_payload (uop_payload),
    .uop_last    (uop_last)
);

// File: tb/ordexp_fence_expander_bench.sv
// Bench: behavioural queue model of expected micro-ops, compared every cycle.
module ordexp_fence_expander_bench;

    localparam int PW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_atomic = 1'b0;
    logic          in_acq = 1'b0;
    logic          in_rel = 1'b0;
    logic [PW-1:0] in_payload = '0;
    logic          uop_valid;
    logic          uop_ready = 1'b1;
    logic [1:0]    uop_kind;
    logic [PW-1:0] uop_payload;
    logic          uop_last;

    typedef struct {
        logic [1:0]    kind;
        logic [PW-1:0] pay;
        logic          last;
        int            req;
    } exp_t;

    exp_t q[$];
    int   tests = 0;
    int   fails = 0;
    int   pushed = 0;
    int   taken = 0;
    int   rdy_mode = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    ordexp_fence_expander #(.PAYLOAD_W(PW)) u_ordexp_fence_expander (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_atomic(in_atomic), .in_acq(in_acq), .in_rel(in_rel), .in_payload(in_payload),
        .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_kind(uop_kind),
        .uop_payload(uop_payload), .uop_last(uop_last)
    );

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Expected expansion, built from the requirement text (R2..R7).
    function automatic void expand(input bit at, input bit acq, input bit rel,
                                   input logic [PW-1:0] p);
        int req;
        if (!at)             req = 2;
        else if (acq && rel) req = 6;
        else if (acq)        req = 4;
        else if (rel)        req = 5;
        else                 req = 3;
        if (!at) begin
            q.push_back('{2'b00, p, 1'b1, req});
            pushed++;
        end else begin
            if (rel) begin q.push_back('{2'b10, '0, 1'b0, req}); pushed++; end
            q.push_back('{2'b01, p, !acq, req});
            pushed++;
            if (acq) begin q.push_back('{2'b11, '0, 1'b1, req}); pushed++; end
        end
    endfunction

    // Sink readiness pattern, changed away from the active edge.
    always @(negedge clk) begin
        case (rdy_mode)
            0: uop_ready <= 1'b1;
            1: uop_ready <= 1'b0;
            2: uop_ready <= 1'($urandom % 2);
            default: uop_ready <= (($urandom % 4) != 0);
        endcase
    end

    // Per-cycle comparison against the model, then model update for the coming edge.
    always @(negedge clk) begin
        if (mon_on) begin
            #1;
            chk(uop_valid == (q.size() > 0), 9, "uop_valid", 64'(uop_valid), 64'(q.size() > 0));
            chk(in_ready == ((q.size() == 0) || (q.size() == 1 && uop_ready)), 8, "in_ready",
                64'(in_ready), 64'((q.size() == 0) || (q.size() == 1 && uop_ready)));
            if (uop_valid && q.size() > 0) begin
                chk(uop_kind == q[0].kind, q[0].req, "uop_kind", 64'(uop_kind), 64'(q[0].kind));
                chk(uop_last == q[0].last, q[0].req, "uop_last", 64'(uop_last), 64'(q[0].last));
                // R7: payload zero on fences, unchanged on the memory op
                chk(uop_payload == q[0].pay, 7, "uop_payload", 64'(uop_payload), 64'(q[0].pay));
            end
            if (uop_valid && uop_ready && q.size() > 0) begin
                void'(q.pop_front());
                taken++;
            end
            if (in_valid && in_ready) expand(in_atomic, in_acq, in_rel, in_payload);
        end
    end

    task automatic send(input bit at, input bit acq, input bit rel, input logic [PW-1:0] p);
        bit acc;
        @(negedge clk);
        in_valid   = 1'b1;
        in_atomic  = at;
        in_acq     = acq;
        in_rel     = rel;
        in_payload = p;
        forever begin
            #1;
            acc = in_ready;
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
        end
    endtask

    task automatic idle_drain();
        int n = 0;
        @(negedge clk);
        in_valid = 1'b0;
        while (q.size() != 0 && n < 2000) begin
            @(posedge clk);
            n++;
        end
        repeat (2) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: state after reset
        chk(!uop_valid, 1, "reset uop_valid", 64'(uop_valid), 64'd0);
        chk(in_ready, 1, "reset in_ready", 64'(in_ready), 64'd1);
        mon_on = 1'b1;

        // R2: plain with ordering bits set, bits ignored
        send(1'b0, 1'b1, 1'b1, 32'hCAFE_0001);
        // R3, R4, R5, R6 directed
        send(1'b1, 1'b0, 1'b0, 32'h1111_0003);
        send(1'b1, 1'b1, 1'b0, 32'h2222_0004);
        send(1'b1, 1'b0, 1'b1, 32'h3333_0005);
        send(1'b1, 1'b1, 1'b1, 32'h4444_0006);
        send(1'b0, 1'b0, 1'b0, 32'h5555_0002);
        send(1'b0, 1'b0, 1'b0, 32'h6666_0002);
        idle_drain();

        // R9: long stall on a three-entry expansion
        rdy_mode = 1;
        send(1'b1, 1'b1, 1'b1, 32'hABCD_0009);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (6) @(posedge clk);
        rdy_mode = 0;
        idle_drain();

        // R8, R9: random streams under random back-pressure
        rdy_mode = 2;
        for (int i = 0; i < 400; i++)
            send(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), $urandom);
        rdy_mode = 3;
        for (int i = 0; i < 200; i++)
            send(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), $urandom);
        rdy_mode = 0;
        idle_drain();

        // R9: everything expected was delivered exactly once
        chk(q.size() == 0, 9, "queue drained", 64'(q.size()), 64'd0);
        chk(taken == pushed, 9, "uops delivered", 64'(taken), 64'(pushed));
        finish_run();
    end

endmodule